// File: doc/BRIEF.md
# Software-Refilled Two-Way Address Translation Buffer

This block translates 40-bit virtual addresses into 36-bit physical addresses for 16 KB pages. It holds 512 mappings in 256 sets of two ways. The 26-bit virtual page number is split into two parts. Its lower 8 bits select a set, and its upper 18 bits are compared against the tag stored in each way. The low 14 address bits are the page offset and pass through unchanged. A lookup is resolved combinationally. Its result (physical address, hit, miss-trap and protection-fault flags) is registered on the next rising clock edge.

The block never walks a page table. When a lookup misses, it only raises the miss-trap flag, and system software installs a mapping through the refill port. On the refill port, software names a set and either an explicit way or automatic victim choice. It also supplies the valid, dirty, access-rights, tag and physical-page fields. A maintenance port can clear every reference bit in one cycle. The same port reads back any entry combinationally.

Each entry has its own dirty and reference bits, and each set has a one-bit least-recently-used pointer. A permitted access updates these on a hit, so that software can decide which pages to write back or age.

Top module: `soft_tlb`

## Requirements
- R1: A lookup strobed in cycle N that matches a valid way with sufficient rights asserts the hit flag after the next rising edge. In that same cycle the physical address equals the entry's 22-bit page number in bits 35:14 joined with virtual address bits 13:0. The set index is virtual bits 21:14 and the tag is virtual bits 39:22.
- R2: A strobed lookup with no valid matching way in its set asserts only the miss-trap flag, with the physical address zero. The stored entries stay unchanged.
- R3: Access rights are encoded as follows: 00 allows no access, 01 allows reads only, and 10 and 11 allow reads and writes. A matching access that the rights forbid asserts only the fault flag, with the physical address zero. A fault leaves the entry's dirty and reference bits untouched.
- R4: A write that hits sets the entry's dirty bit. A read hit leaves the dirty bit as it was.
- R5: Every hit sets the entry's reference bit. The clear command zeroes all reference bits. If a hit occurs in the same cycle as the clear, the hit entry's reference bit ends up set.
- R6: A refill writes all fields of the chosen entry and zeroes its reference bit. The way-select code 00 picks way 0, 01 picks way 1, and 1x picks automatically. A refill with its valid input low invalidates the entry.
- R7: An automatic refill picks an invalid way first, taking way 0 when both are invalid. Otherwise it picks the way named by the set's LRU pointer.
- R8: A hit in way w sets its set's LRU pointer to the other way. A refill into way w does the same.
- R9: When a refill and a lookup target the same set in one cycle, the lookup sees the newly written entry.
- R10: At most one of the hit, miss and fault flags is high at a time. All three are low in the cycle after a cycle without a strobe.
- R11: The asynchronous active-low reset clears every valid, dirty and reference bit and every LRU pointer to way 0. It also drives all lookup outputs to zero.
- R12: The readback outputs show the fields of the entry selected by the readback set and way inputs in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| lk_req_i | input | 1 | Lookup strobe |
| lk_vaddr_i | input | 40 | Virtual address |
| lk_write_i | input | 1 | 1 = write access, 0 = read |
| lk_paddr_o | output | 36 | Registered physical address (zero unless hit) |
| lk_hit_o | output | 1 | Registered hit flag |
| lk_miss_o | output | 1 | Registered miss-trap flag |
| lk_fault_o | output | 1 | Registered protection-fault flag |
| rf_req_i | input | 1 | Refill strobe |
| rf_set_i | input | 8 | Refill set |
| rf_way_i | input | 2 | Way select: 00 way 0, 01 way 1, 1x automatic |
| rf_vld_i | input | 1 | Valid bit to write |
| rf_dirty_i | input | 1 | Dirty bit to write |
| rf_rights_i | input | 2 | Access rights to write |
| rf_tag_i | input | 18 | Tag to write |
| rf_ppn_i | input | 22 | Physical page number to write |
| mt_clr_ref_i | input | 1 | Clear all reference bits |
| mt_set_i | input | 8 | Readback set |
| mt_way_i | input | 1 | Readback way |
| mt_vld_o | output | 1 | Readback valid bit |
| mt_dirty_o | output | 1 | Readback dirty bit |
| mt_ref_o | output | 1 | Readback reference bit |
| mt_rights_o | output | 2 | Readback access rights |
| mt_tag_o | output | 18 | Readback tag |
| mt_ppn_o | output | 22 | Readback physical page number |

## Verification
Lookups are tried with tags that hit in either way, tags that match in a neighbouring set only, reads and writes against each rights code, and offsets at both extremes. This separates a way-select error, a set-index error, a rights decode error and offset corruption. Readback after these lookups shows whether dirty and reference updates landed on the right entry and spared faulted ones. Victim choice is exercised in three kinds of set: one that is empty, one with a deliberately invalidated way whose LRU pointer names the valid way, and one whose pointer was moved by hits and refills. This tells the invalid-first rule apart from the LRU rule. A refill and a lookup issued together to an empty set reveal whether the bypass gives the refill priority.

// File: rtl/soft_tlb_pkg.sv
package soft_tlb_pkg;
  localparam int VA_W   = 40;
  localparam int PA_W   = 36;
  localparam int OFF_W  = 14;
  localparam int SET_W  = 8;
  localparam int VPN_W  = VA_W - OFF_W;
  localparam int TAG_W  = VPN_W - SET_W;
  localparam int PPN_W  = PA_W - OFF_W;
  localparam int N_SETS = 1 << SET_W;
  localparam int N_WAYS = 2;

  typedef enum logic [1:0] {
    AR_NONE = 2'b00,
    AR_RO   = 2'b01,
    AR_RW   = 2'b10,
    AR_RWX  = 2'b11
  } rights_e;

  typedef struct packed {
    logic             vld;
    logic             dirty;
    logic             refd;
    rights_e          rights;
    logic [TAG_W-1:0] tag;
    logic [PPN_W-1:0] ppn;
  } entry_t;
endpackage

// File: rtl/tlb_way_match.sv
module tlb_way_match
  import soft_tlb_pkg::*;
(
  input  logic             vld_i,
  input  logic [TAG_W-1:0] ent_tag_i,
  input  logic [TAG_W-1:0] lk_tag_i,
  output logic             match_o
);
  assign match_o = vld_i && (ent_tag_i == lk_tag_i);
endmodule

// File: rtl/tlb_rights_chk.sv
module tlb_rights_chk
  import soft_tlb_pkg::*;
(
  input  rights_e rights_i,
  input  logic    write_i,
  output logic    allow_o
);
  always_comb begin
    unique case (rights_i)
      AR_NONE:        allow_o = 1'b0;
      AR_RO:          allow_o = !write_i;
      AR_RW, AR_RWX:  allow_o = 1'b1;
      default:        allow_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/tlb_victim_sel.sv
module tlb_victim_sel (
  input  logic       vld0_i,
  input  logic       vld1_i,
  input  logic       lru_i,
  input  logic [1:0] way_sel_i,
  output logic       way_o
);
  always_comb begin
    if (!way_sel_i[1])  way_o = way_sel_i[0];
    else if (!vld0_i)   way_o = 1'b0;
    else if (!vld1_i)   way_o = 1'b1;
    else                way_o = lru_i;
  end
endmodule

// File: rtl/soft_tlb.sv
module soft_tlb
  import soft_tlb_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             lk_req_i,
  input  logic [VA_W-1:0]  lk_vaddr_i,
  input  logic             lk_write_i,
  output logic [PA_W-1:0]  lk_paddr_o,
  output logic             lk_hit_o,
  output logic             lk_miss_o,
  output logic             lk_fault_o,
  input  logic             rf_req_i,
  input  logic [SET_W-1:0] rf_set_i,
  input  logic [1:0]       rf_way_i,
  input  logic             rf_vld_i,
  input  logic             rf_dirty_i,
  input  logic [1:0]       rf_rights_i,
  input  logic [TAG_W-1:0] rf_tag_i,
  input  logic [PPN_W-1:0] rf_ppn_i,
  input  logic             mt_clr_ref_i,
  input  logic [SET_W-1:0] mt_set_i,
  input  logic             mt_way_i,
  output logic             mt_vld_o,
  output logic             mt_dirty_o,
  output logic             mt_ref_o,
  output logic [1:0]       mt_rights_o,
  output logic [TAG_W-1:0] mt_tag_o,
  output logic [PPN_W-1:0] mt_ppn_o
);
  entry_t              tbl_q [N_SETS][N_WAYS];
  logic [N_SETS-1:0]   lru_q;

  logic [SET_W-1:0]    lk_set;
  logic [TAG_W-1:0]    lk_tag;
  logic [OFF_W-1:0]    lk_off;
  assign lk_off = lk_vaddr_i[OFF_W-1:0];
  assign lk_set = lk_vaddr_i[OFF_W +: SET_W];
  assign lk_tag = lk_vaddr_i[VA_W-1 -: TAG_W];

  // refill victim
  logic   rf_way;
  entry_t rf_ent;
  tlb_victim_sel u_victim (
    .vld0_i    (tbl_q[rf_set_i][0].vld),
    .vld1_i    (tbl_q[rf_set_i][1].vld),
    .lru_i     (lru_q[rf_set_i]),
    .way_sel_i (rf_way_i),
    .way_o     (rf_way)
  );

  always_comb begin
    rf_ent        = '0;
    rf_ent.vld    = rf_vld_i;
    rf_ent.dirty  = rf_dirty_i;
    rf_ent.refd   = 1'b0;
    rf_ent.rights = rights_e'(rf_rights_i);
    rf_ent.tag    = rf_tag_i;
    rf_ent.ppn    = rf_ppn_i;
  end

  // lookup sees same-cycle refill first
  entry_t            eff [N_WAYS];
  logic [N_WAYS-1:0] match;
  for (genvar w = 0; w < N_WAYS; w++) begin : g_way
    assign eff[w] = (rf_req_i && rf_set_i == lk_set && rf_way == 1'(w))
                    ? rf_ent : tbl_q[lk_set][w];
    tlb_way_match u_match (
      .vld_i     (eff[w].vld),
      .ent_tag_i (eff[w].tag),
      .lk_tag_i  (lk_tag),
      .match_o   (match[w])
    );
  end

  logic   hit_way;
  entry_t hit_ent;
  entry_t upd_ent;
  logic   allow;
  logic   do_hit, do_miss, do_fault;

  assign hit_way = !match[0];
  assign hit_ent = eff[hit_way];

  tlb_rights_chk u_rights (
    .rights_i (hit_ent.rights),
    .write_i  (lk_write_i),
    .allow_o  (allow)
  );

  assign do_hit   = lk_req_i && (|match) && allow;
  assign do_fault = lk_req_i && (|match) && !allow;
  assign do_miss  = lk_req_i && !(|match);

  always_comb begin
    upd_ent       = hit_ent;
    upd_ent.refd  = 1'b1;
    upd_ent.dirty = hit_ent.dirty | lk_write_i;
  end

  // storage: clear, then refill, then hit update (later wins)
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < N_SETS; s++)
        for (int w = 0; w < N_WAYS; w++)
          tbl_q[s][w] <= '0;
      lru_q <= '0;
    end else begin
      if (mt_clr_ref_i)
        for (int s = 0; s < N_SETS; s++)
          for (int w = 0; w < N_WAYS; w++)
            tbl_q[s][w].refd <= 1'b0;
      if (rf_req_i) begin
        tbl_q[rf_set_i][rf_way] <= rf_ent;
        lru_q[rf_set_i]         <= ~rf_way;
      end
      if (do_hit) begin
        tbl_q[lk_set][hit_way] <= upd_ent;
        lru_q[lk_set]          <= ~hit_way;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lk_hit_o   <= 1'b0;
      lk_miss_o  <= 1'b0;
      lk_fault_o <= 1'b0;
      lk_paddr_o <= '0;
    end else begin
      lk_hit_o   <= do_hit;
      lk_miss_o  <= do_miss;
      lk_fault_o <= do_fault;
      lk_paddr_o <= do_hit ? {hit_ent.ppn, lk_off} : '0;
    end
  end

  entry_t mt_ent;
  assign mt_ent      = tbl_q[mt_set_i][mt_way_i];
  assign mt_vld_o    = mt_ent.vld;
  assign mt_dirty_o  = mt_ent.dirty;
  assign mt_ref_o    = mt_ent.refd;
  assign mt_rights_o = mt_ent.rights;
  assign mt_tag_o    = mt_ent.tag;
  assign mt_ppn_o    = mt_ent.ppn;
endmodule

// File: rtl/soft_tlb_chk.sv
module soft_tlb_chk
  import soft_tlb_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             lk_req_i,
  input logic [VA_W-1:0]  lk_vaddr_i,
  input logic [PA_W-1:0]  lk_paddr_o,
  input logic             lk_hit_o,
  input logic             lk_miss_o,
  input logic             lk_fault_o,
  input logic             mt_clr_ref_i,
  input logic             mt_ref_o
);
  assert_flags_onehot_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({lk_hit_o, lk_miss_o, lk_fault_o}));

  assert_answer_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_req_i |=> (lk_hit_o || lk_miss_o || lk_fault_o));

  assert_quiet_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lk_req_i |=> !(lk_hit_o || lk_miss_o || lk_fault_o));

  assert_offset_pass_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_hit_o |-> lk_paddr_o[OFF_W-1:0] == $past(lk_vaddr_i[OFF_W-1:0]));

  assert_paddr_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lk_miss_o || lk_fault_o) |-> lk_paddr_o == '0);

  assert_ref_cleared_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mt_clr_ref_i && !lk_req_i) |=> !mt_ref_o);
endmodule

bind soft_tlb soft_tlb_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .lk_req_i     (lk_req_i),
  .lk_vaddr_i   (lk_vaddr_i),
  .lk_paddr_o   (lk_paddr_o),
  .lk_hit_o     (lk_hit_o),
  .lk_miss_o    (lk_miss_o),
  .lk_fault_o   (lk_fault_o),
  .mt_clr_ref_i (mt_clr_ref_i),
  .mt_ref_o     (mt_ref_o)
);

// File: tb/soft_tlb_tb.sv
`timescale 1ns/1ps
module soft_tlb_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lk_req = 1'b0;
  logic [39:0] lk_vaddr = '0;
  logic        lk_write = 1'b0;
  logic [35:0] lk_paddr;
  logic        lk_hit, lk_miss, lk_fault;
  logic        rf_req = 1'b0;
  logic [7:0]  rf_set = '0;
  logic [1:0]  rf_way = '0;
  logic        rf_vld = 1'b0;
  logic        rf_dirty = 1'b0;
  logic [1:0]  rf_rights = '0;
  logic [17:0] rf_tag = '0;
  logic [21:0] rf_ppn = '0;
  logic        mt_clr = 1'b0;
  logic [7:0]  mt_set = '0;
  logic        mt_way = 1'b0;
  logic        mt_vld, mt_dirty, mt_ref;
  logic [1:0]  mt_rights;
  logic [17:0] mt_tag;
  logic [21:0] mt_ppn;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  soft_tlb u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .lk_req_i(lk_req), .lk_vaddr_i(lk_vaddr), .lk_write_i(lk_write),
    .lk_paddr_o(lk_paddr), .lk_hit_o(lk_hit), .lk_miss_o(lk_miss), .lk_fault_o(lk_fault),
    .rf_req_i(rf_req), .rf_set_i(rf_set), .rf_way_i(rf_way), .rf_vld_i(rf_vld),
    .rf_dirty_i(rf_dirty), .rf_rights_i(rf_rights), .rf_tag_i(rf_tag), .rf_ppn_i(rf_ppn),
    .mt_clr_ref_i(mt_clr), .mt_set_i(mt_set), .mt_way_i(mt_way),
    .mt_vld_o(mt_vld), .mt_dirty_o(mt_dirty), .mt_ref_o(mt_ref),
    .mt_rights_o(mt_rights), .mt_tag_o(mt_tag), .mt_ppn_o(mt_ppn)
  );

  typedef struct packed {
    logic [39:0] va;
    logic        wr;
    logic [2:0]  flags;  // hit, miss, fault
    logic [35:0] pa;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{{18'h12345, 8'd5,   14'h1234}, 1'b0, 3'b100, {22'h0ABCDE, 14'h1234}},
    '{{18'h12345, 8'd5,   14'h0000}, 1'b1, 3'b100, {22'h0ABCDE, 14'h0000}},
    '{{18'h00001, 8'd5,   14'h3FFF}, 1'b0, 3'b100, {22'h111111, 14'h3FFF}},
    '{{18'h00001, 8'd5,   14'h0010}, 1'b1, 3'b001, 36'h0},
    '{{18'h3FFFF, 8'd9,   14'h0100}, 1'b0, 3'b001, 36'h0},
    '{{18'h2AAAA, 8'd255, 14'h0001}, 1'b1, 3'b100, {22'h155555, 14'h0001}},
    '{{18'h00002, 8'd5,   14'h0000}, 1'b0, 3'b010, 36'h0},
    '{{18'h12345, 8'd6,   14'h0000}, 1'b0, 3'b010, 36'h0},
    '{{18'h00000, 8'd0,   14'h0000}, 1'b1, 3'b010, 36'h0}
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  task automatic lookup(input logic [39:0] va, input logic wr);
    @(negedge clk);
    lk_req = 1'b1; lk_vaddr = va; lk_write = wr;
    @(negedge clk);
    lk_req = 1'b0; lk_write = 1'b0;
  endtask

  task automatic refill(input logic [7:0] s, input logic [1:0] w, input logic v,
                        input logic [1:0] r, input logic [17:0] t, input logic [21:0] p);
    @(negedge clk);
    rf_req = 1'b1; rf_set = s; rf_way = w; rf_vld = v; rf_dirty = 1'b0;
    rf_rights = r; rf_tag = t; rf_ppn = p;
    @(negedge clk);
    rf_req = 1'b0;
  endtask

  task automatic peek(input logic [7:0] s, input logic w);
    mt_set = s; mt_way = w;
    #1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
    $finish;
  end

  initial begin
    // R11 reset state
    #55;
    chk("R11 flags", {lk_hit, lk_miss, lk_fault}, 3'b000);
    chk("R11 paddr", lk_paddr, 36'h0);
    peek(8'd5, 1'b0);
    chk("R11 valid", mt_vld, 1'b0);
    @(negedge clk); rst_n = 1'b1;

    refill(8'd5,   2'b00, 1'b1, 2'b10, 18'h12345, 22'h0ABCDE);
    refill(8'd5,   2'b01, 1'b1, 2'b01, 18'h00001, 22'h111111);
    refill(8'd9,   2'b00, 1'b1, 2'b00, 18'h3FFFF, 22'h3FFFFF);
    refill(8'd255, 2'b10, 1'b1, 2'b11, 18'h2AAAA, 22'h155555);

    // R6/R12 readback of explicit refill
    peek(8'd5, 1'b1);
    chk("R6 tag way1", mt_tag, 18'h00001);
    chk("R12 ppn way1", mt_ppn, 22'h111111);
    chk("R6 rights way1", mt_rights, 2'b01);
    // R7 both invalid -> way 0
    peek(8'd255, 1'b0);
    chk("R7 auto empty to way0", {mt_vld, mt_tag}, {1'b1, 18'h2AAAA});

    for (int i = 0; i < NV; i++) begin
      lookup(VECS[i].va, VECS[i].wr);
      if (VECS[i].flags[0])      chk("R3 flags", {lk_hit, lk_miss, lk_fault}, VECS[i].flags);
      else if (VECS[i].flags[1]) chk("R2 flags", {lk_hit, lk_miss, lk_fault}, VECS[i].flags);
      else                       chk("R1 flags", {lk_hit, lk_miss, lk_fault}, VECS[i].flags);
      chk("R1 paddr", lk_paddr, VECS[i].pa);
    end

    // R10 quiet after idle cycle
    @(negedge clk);
    chk("R10 idle flags", {lk_hit, lk_miss, lk_fault}, 3'b000);

    // R4/R5/R3/R2 state after table
    peek(8'd5, 1'b0);
    chk("R4 dirty after write hit", {mt_dirty, mt_ref}, 2'b11);
    chk("R2 entry unchanged by miss", mt_tag, 18'h12345);
    peek(8'd5, 1'b1);
    chk("R3 fault keeps clean, R4 read no dirty", {mt_dirty, mt_ref}, 2'b01);
    peek(8'd9, 1'b0);
    chk("R3 fault no ref", mt_ref, 1'b0);

    // R5 clear all, then clear with hit
    @(negedge clk); mt_clr = 1'b1;
    @(negedge clk); mt_clr = 1'b0;
    peek(8'd5, 1'b0);
    chk("R5 cleared way0", mt_ref, 1'b0);
    peek(8'd255, 1'b0);
    chk("R5 cleared set255", mt_ref, 1'b0);
    @(negedge clk);
    mt_clr = 1'b1; lk_req = 1'b1; lk_vaddr = {18'h12345, 8'd5, 14'h0}; lk_write = 1'b0;
    @(negedge clk);
    mt_clr = 1'b0; lk_req = 1'b0;
    chk("R5 hit with clear", lk_hit, 1'b1);
    peek(8'd5, 1'b0);
    chk("R5 hit ref survives clear", mt_ref, 1'b1);
    peek(8'd5, 1'b1);
    chk("R5 other ref cleared", mt_ref, 1'b0);

    // R8/R7: last hit way0 -> LRU way1
    refill(8'd5, 2'b10, 1'b1, 2'b10, 18'h00777, 22'h000777);
    peek(8'd5, 1'b1);
    chk("R8 auto to LRU way1", mt_tag, 18'h00777);
    peek(8'd5, 1'b0);
    chk("R8 way0 kept", mt_tag, 18'h12345);
    refill(8'd5, 2'b10, 1'b1, 2'b10, 18'h00888, 22'h000888);
    peek(8'd5, 1'b0);
    chk("R8 refill moves LRU to way0", mt_tag, 18'h00888);
    lookup({18'h00888, 8'd5, 14'h0}, 1'b0);
    chk("R1 hit new entry", lk_paddr, {22'h000888, 14'h0});
    refill(8'd5, 2'b10, 1'b1, 2'b10, 18'h00999, 22'h000999);
    peek(8'd5, 1'b1);
    chk("R8 hit moves LRU to way1", mt_tag, 18'h00999);

    // R7 invalid way preferred over LRU
    refill(8'd40, 2'b00, 1'b1, 2'b10, 18'h00040, 22'h000040);
    refill(8'd40, 2'b01, 1'b0, 2'b10, 18'h00000, 22'h000000);
    peek(8'd40, 1'b1);
    chk("R6 invalidating refill", mt_vld, 1'b0);
    refill(8'd40, 2'b11, 1'b1, 2'b10, 18'h00041, 22'h000041);
    peek(8'd40, 1'b1);
    chk("R7 invalid way first", {mt_vld, mt_tag}, {1'b1, 18'h00041});
    peek(8'd40, 1'b0);
    chk("R7 valid way kept", mt_tag, 18'h00040);

    // R9 same-cycle refill and lookup
    @(negedge clk);
    rf_req = 1'b1; rf_set = 8'd60; rf_way = 2'b00; rf_vld = 1'b1; rf_dirty = 1'b0;
    rf_rights = 2'b10; rf_tag = 18'h0BEEF; rf_ppn = 22'h0C0FFE;
    lk_req = 1'b1; lk_vaddr = {18'h0BEEF, 8'd60, 14'h2A5A}; lk_write = 1'b1;
    @(negedge clk);
    rf_req = 1'b0; lk_req = 1'b0; lk_write = 1'b0;
    chk("R9 bypass hit", {lk_hit, lk_miss, lk_fault}, 3'b100);
    chk("R9 bypass paddr", lk_paddr, {22'h0C0FFE, 14'h2A5A});
    peek(8'd60, 1'b0);
    chk("R9 write dirty on new entry", {mt_dirty, mt_ref}, 2'b11);

    // R11 reset mid-run
    @(negedge clk); rst_n = 1'b0;
    #5;
    peek(8'd5, 1'b0);
    chk("R11 cleared valid", {mt_vld, mt_dirty, mt_ref}, 3'b000);
    @(negedge clk); rst_n = 1'b1;
    lookup({18'h00888, 8'd5, 14'h0}, 1'b0);
    chk("R11 miss after reset", {lk_hit, lk_miss, lk_fault}, 3'b010);

    summary();
    $finish;
  end
endmodule